// File: doc/BRIEF.md
# Multi-mode backplane frame sync generator

This block keeps the bit position of the transmit frame on a T1/E1 framer's system-side serial backplane. A bit counter runs on the backplane bit clock and counts one 125 us frame in the selected mode. The modes are base-rate T1, base-rate E1, high-speed backplanes at 2.048, 4.096 and 8.192 Mbit/s, and two multiplexed-bus variants. From the counter the block produces a timeslot number and a DS0 channel index. It also sets a flag on every bit that carries no channel data, which covers the skipped slots when 24 T1 channels ride in a 32-slot high-speed frame.

In base-rate modes a configuration bit decides the direction of the frame pulse. The block can drive its own one-bit frame pulse, or it can accept an external pulse, lock to it and report misplaced arrivals. The high-speed modes only accept an external pulse. Each mode places that pulse in its own way: one bit at frame start, two bits across the frame seam, or four bits across the seam. A new mode or configuration takes effect only at the next frame boundary.

Top module: `fsync_gen`

## Requirements
- R1: `bit_cnt` counts 0 to L-1 and then wraps to 0. L is set by `cfg_mode`: 0 = base T1 (L=193), 1 = base E1 (256), 2 = 2.048 high-speed (256), 3 = 4.096 high-speed (512), 4 = 8.192 high-speed (1024), 5 = four-bit-pulse bus (1024), 6 = two-bit-pulse bus (1024), 7 = treated as code 4.
- R2: In a base-rate mode with `cfg_sync_in`=0 the block drives the pulse. `sync_out` is high exactly while `bit_cnt`=0, for one cycle per frame.
- R3: Input mode applies when the mode code is 2 or higher, or when `cfg_sync_in`=1. In input mode `sync_out` stays low. In output mode `ext_sync` has no effect on any output.
- R4: In input mode a rising edge of `ext_sync` realigns the counter. The cycle in which `ext_sync` is first seen high is taken to be position E, so `bit_cnt` reads E+1 (mod L) in the following cycle. E is L-2 for code 5, L-1 for code 6 and 0 otherwise.
- R5: `sync_err` is high for exactly the one cycle after an accepted edge, and only when the counter did not read E in the edge cycle.
- R6: `slot_cnt` in base T1 is 0 at position 0 and (pos-1)/8 elsewhere. In every other mode it is pos/(8*2^k), with k=0 for codes 1 and 2, k=1 for code 3 and k=2 otherwise.
- R7: `dont_care` is high at position 0 in base T1. In high-speed modes with `cfg_t1`=1 it is high in slots 0, 4, 8 ... 28. Elsewhere it is low. While `dont_care` is high, `ds0_chan` is 0. In high-speed T1 it is otherwise slot - slot/4 - 1, giving 0 to 23. In all other cases it equals `slot_cnt`.
- R8: `cfg_mode`, `cfg_t1` and `cfg_sync_in` are taken in only when `bit_cnt` moves to 0.
- R9: While `rst` is high, `sync_out` and `sync_err` are low, `bit_cnt` is held at L-1 of the configured mode, and the configuration is loaded directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Backplane bit clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 3 | Backplane mode code |
| cfg_t1 | input | 1 | 1 = T1 channels carried on a high-speed backplane |
| cfg_sync_in | input | 1 | Base-rate modes: 1 = pulse is an input |
| ext_sync | input | 1 | External frame pulse |
| sync_out | output | 1 | Generated frame pulse |
| sync_err | output | 1 | Misplaced external pulse seen |
| bit_cnt | output | 10 | Bit position in frame |
| slot_cnt | output | 5 | Timeslot number |
| ds0_chan | output | 5 | DS0 channel index |
| dont_care | output | 1 | Bit carries no channel data |

## Verification
The bench builds the block with its default slot width of 8 bits, 32 slots and 24 T1 channels. With these values every mode has a real frame length, at most 1024 bits, so several whole frames of each mode fit easily in one run. This lets the bench reach both seam-straddling pulse shapes, the frame wrap right after an H.100-style lock edge, mode changes made in the middle of a frame, and a reset taken in the middle of a run.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

  typedef enum logic [2:0] {
    MODE_T1_BASE = 3'd0,
    MODE_E1_BASE = 3'd1,
    MODE_HS_2M   = 3'd2,
    MODE_HS_4M   = 3'd3,
    MODE_HS_8M   = 3'd4,
    MODE_MUX_W4  = 3'd5,
    MODE_MUX_W2  = 3'd6,
    MODE_RSVD    = 3'd7
  } fsg_mode_e;

  typedef struct packed {
    fsg_mode_e mode;
    logic      t1;
    logic      ext_in;
  } fsg_cfg_t;

  // bits per 125 us frame for a mode
  function automatic int frame_bits(fsg_mode_e m, int slot_bits, int e1_slots, int t1_chans);
    case (m)
      MODE_T1_BASE:             return t1_chans * slot_bits + 1;
      MODE_E1_BASE, MODE_HS_2M: return e1_slots * slot_bits;
      MODE_HS_4M:               return 2 * e1_slots * slot_bits;
      default:                  return 4 * e1_slots * slot_bits;
    endcase
  endfunction

endpackage

// File: rtl/fsg_mode_decode.sv
module fsg_mode_decode
  import fsg_pkg::*;
#(
  parameter int SLOT_BITS = 8,
  parameter int E1_SLOTS  = 32,
  parameter int T1_CHANS  = 24,
  parameter int CNT_W     = 10
) (
  input  fsg_mode_e          mode,
  output logic [CNT_W-1:0]   last_pos,
  output logic [CNT_W-1:0]   first_pos,
  output logic [1:0]         rate_k,
  output logic               hs
);

  always_comb begin
    last_pos = CNT_W'(frame_bits(mode, SLOT_BITS, E1_SLOTS, T1_CHANS) - 1);
    case (mode)
      MODE_T1_BASE, MODE_E1_BASE, MODE_HS_2M: rate_k = 2'd0;
      MODE_HS_4M:                             rate_k = 2'd1;
      default:                                rate_k = 2'd2;
    endcase
    case (mode)
      MODE_MUX_W4: first_pos = last_pos - CNT_W'(1);
      MODE_MUX_W2: first_pos = last_pos;
      default:     first_pos = '0;
    endcase
    hs = (mode != MODE_T1_BASE) && (mode != MODE_E1_BASE);
  end

endmodule

// File: rtl/fsg_bit_counter.sv
module fsg_bit_counter
  import fsg_pkg::*;
#(
  parameter int SLOT_BITS = 8,
  parameter int E1_SLOTS  = 32,
  parameter int T1_CHANS  = 24,
  parameter int CNT_W     = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  fsg_cfg_t         cfg_in,
  input  logic             ext_sync,
  input  logic [CNT_W-1:0] act_last,
  input  logic [CNT_W-1:0] act_first,
  input  logic             act_hs,
  output fsg_cfg_t         act_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             sync_q,
  output logic             err_q
);

  logic             ext_q;
  logic             in_mode;
  logic             lock;
  logic [CNT_W-1:0] cnt_d;
  fsg_cfg_t         act_d;
  logic             drive_d;
  logic [CNT_W-1:0] rst_last;

  always_comb begin
    rst_last = CNT_W'(frame_bits(cfg_in.mode, SLOT_BITS, E1_SLOTS, T1_CHANS) - 1);
    in_mode  = act_hs | act_q.ext_in;
    lock     = in_mode & ext_sync & ~ext_q;
    if (lock)
      cnt_d = (act_first == act_last) ? '0 : act_first + CNT_W'(1);
    else
      cnt_d = (cnt_q >= act_last) ? '0 : cnt_q + CNT_W'(1);
    act_d   = (cnt_d == '0) ? cfg_in : act_q;
    drive_d = (act_d.mode == MODE_T1_BASE || act_d.mode == MODE_E1_BASE) & ~act_d.ext_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= rst_last;
      act_q  <= cfg_in;
      sync_q <= 1'b0;
      err_q  <= 1'b0;
      ext_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      act_q  <= act_d;
      sync_q <= drive_d & (cnt_d == '0);
      err_q  <= lock & (cnt_q != act_first);
      ext_q  <= ext_sync;
    end
  end

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= act_last);

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!lock && cnt_q != act_last) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  // R2
  sync_width_chk: assert property (@(posedge clk) disable iff (rst)
    sync_q |=> !sync_q);

  // R3
  in_mode_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (act_hs || act_q.ext_in) |-> !sync_q);

  // R5
  err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    err_q |=> !err_q);

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0 && !$past(rst)) |-> $stable(act_q));

endmodule

// File: rtl/fsg_slot_map.sv
module fsg_slot_map #(
  parameter int SLOT_BITS = 8,
  parameter int CNT_W     = 10,
  parameter int SLOT_W    = 5
) (
  input  logic [CNT_W-1:0]  pos,
  input  logic              t1_base,
  input  logic              hs,
  input  logic              t1_on_hs,
  input  logic [1:0]        rate_k,
  output logic [SLOT_W-1:0] slot,
  output logic [SLOT_W-1:0] chan,
  output logic              dc
);

  localparam int LB = $clog2(SLOT_BITS);

  logic [CNT_W-1:0] pos_m1;
  logic             skip_map;

  always_comb begin
    pos_m1   = pos - CNT_W'(1);
    skip_map = hs & t1_on_hs;
    if (t1_base) begin
      slot = (pos == '0) ? '0 : SLOT_W'(pos_m1 >> LB);
      dc   = (pos == '0);
    end else begin
      slot = SLOT_W'(pos >> (LB + int'(rate_k)));
      dc   = skip_map & (slot[1:0] == 2'b00);
    end
    if (dc)
      chan = '0;
    else if (skip_map)
      chan = slot - (slot >> 2) - SLOT_W'(1);
    else
      chan = slot;
  end

endmodule

// File: rtl/fsync_gen.sv
module fsync_gen
  import fsg_pkg::*;
#(
  parameter int SLOT_BITS = 8,
  parameter int E1_SLOTS  = 32,
  parameter int T1_CHANS  = 24,
  localparam int MAX_LEN  = 4 * E1_SLOTS * SLOT_BITS,
  localparam int CNT_W    = $clog2(MAX_LEN),
  localparam int SLOT_W   = $clog2(E1_SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cfg_mode,
  input  logic              cfg_t1,
  input  logic              cfg_sync_in,
  input  logic              ext_sync,
  output logic              sync_out,
  output logic              sync_err,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic [SLOT_W-1:0] slot_cnt,
  output logic [SLOT_W-1:0] ds0_chan,
  output logic              dont_care
);

  fsg_cfg_t         cfg_in;
  fsg_cfg_t         act_cfg;
  logic [CNT_W-1:0] act_last;
  logic [CNT_W-1:0] act_first;
  logic [1:0]       act_k;
  logic             act_hs;

  assign cfg_in = '{mode: fsg_mode_e'(cfg_mode), t1: cfg_t1, ext_in: cfg_sync_in};

  fsg_mode_decode #(
    .SLOT_BITS(SLOT_BITS), .E1_SLOTS(E1_SLOTS), .T1_CHANS(T1_CHANS), .CNT_W(CNT_W)
  ) u_dec (
    .mode      (act_cfg.mode),
    .last_pos  (act_last),
    .first_pos (act_first),
    .rate_k    (act_k),
    .hs        (act_hs)
  );

  fsg_bit_counter #(
    .SLOT_BITS(SLOT_BITS), .E1_SLOTS(E1_SLOTS), .T1_CHANS(T1_CHANS), .CNT_W(CNT_W)
  ) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .cfg_in    (cfg_in),
    .ext_sync  (ext_sync),
    .act_last  (act_last),
    .act_first (act_first),
    .act_hs    (act_hs),
    .act_q     (act_cfg),
    .cnt_q     (bit_cnt),
    .sync_q    (sync_out),
    .err_q     (sync_err)
  );

  fsg_slot_map #(
    .SLOT_BITS(SLOT_BITS), .CNT_W(CNT_W), .SLOT_W(SLOT_W)
  ) u_map (
    .pos      (bit_cnt),
    .t1_base  (act_cfg.mode == MODE_T1_BASE),
    .hs       (act_hs),
    .t1_on_hs (act_cfg.t1),
    .rate_k   (act_k),
    .slot     (slot_cnt),
    .chan     (ds0_chan),
    .dc       (dont_care)
  );

  // R7
  ds0_range_chk: assert property (@(posedge clk) disable iff (rst)
    (act_hs && act_cfg.t1 && !dont_care) |-> ds0_chan < SLOT_W'(T1_CHANS));

  // R7
  dc_chan_zero_chk: assert property (@(posedge clk) disable iff (rst)
    dont_care |-> ds0_chan == '0);

endmodule

// File: tb/tb_fsync_gen.sv
`timescale 1ns/1ps
module tb_fsync_gen;

  localparam int SB  = 8;
  localparam int E1S = 32;
  localparam int T1C = 24;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] cfg_mode = 3'd0;
  logic       cfg_t1 = 1'b0;
  logic       cfg_sync_in = 1'b0;
  logic       ext_sync = 1'b0;
  logic       sync_out, sync_err, dont_care;
  logic [9:0] bit_cnt;
  logic [4:0] slot_cnt, ds0_chan;

  always #4 clk = ~clk;

  fsync_gen dut (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_t1(cfg_t1),
    .cfg_sync_in(cfg_sync_in), .ext_sync(ext_sync), .sync_out(sync_out),
    .sync_err(sync_err), .bit_cnt(bit_cnt), .slot_cnt(slot_cnt),
    .ds0_chan(ds0_chan), .dont_care(dont_care)
  );

  int n_chk = 0;
  int n_bad = 0;

  // reference model state
  int  m_pos = 0, m_mode = 0, m_t1 = 0, m_sin = 0;
  bit  m_prev = 0, m_sync = 0, m_err = 0, m_valid = 0, m_inrst = 1;

  function automatic int f_len(int m);
    if (m == 0) return T1C * SB + 1;
    if (m == 1 || m == 2) return E1S * SB;
    if (m == 3) return 2 * E1S * SB;
    return 4 * E1S * SB;
  endfunction

  function automatic int f_first(int m);
    if (m == 5) return f_len(m) - 2;
    if (m == 6) return f_len(m) - 1;
    return 0;
  endfunction

  function automatic int f_div(int m);
    if (m <= 2) return SB;
    if (m == 3) return 2 * SB;
    return 4 * SB;
  endfunction

  always @(posedge clk) begin
    m_valid = 1;
    if (rst) begin
      m_inrst = 1;
      m_mode = cfg_mode; m_t1 = cfg_t1; m_sin = cfg_sync_in;
      m_pos = f_len(m_mode) - 1; m_sync = 0; m_err = 0; m_prev = 0;
    end else begin
      bit inm, edg;
      int npos;
      m_inrst = 0;
      inm = (m_mode >= 2) || (m_sin != 0);
      edg = inm && ext_sync && !m_prev;
      m_prev = ext_sync;
      if (edg) begin
        m_err = (m_pos != f_first(m_mode));
        npos = (f_first(m_mode) + 1) % f_len(m_mode);
      end else begin
        m_err = 0;
        npos = (m_pos + 1) % f_len(m_mode);
      end
      if (npos == 0) begin
        m_mode = cfg_mode; m_t1 = cfg_t1; m_sin = cfg_sync_in;
      end
      m_pos = npos;
      m_sync = (m_mode < 2) && (m_sin == 0) && (m_pos == 0);
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (m_valid) begin
      if (m_inrst) begin
        chk(sync_out == 1'b0, "R9 sync_out in reset", sync_out, 0);
        chk(sync_err == 1'b0, "R9 sync_err in reset", sync_err, 0);
        chk(int'(bit_cnt) == m_pos, "R9 bit_cnt in reset", bit_cnt, m_pos);
      end else begin
        int es, edc, ech;
        bool_t_dummy();
        if (m_mode == 0) begin
          es  = (m_pos == 0) ? 0 : (m_pos - 1) / SB;
          edc = (m_pos == 0);
        end else begin
          es  = m_pos / f_div(m_mode);
          edc = (m_mode >= 2 && m_t1 != 0 && es % 4 == 0);
        end
        if (edc != 0) ech = 0;
        else if (m_mode >= 2 && m_t1 != 0) ech = es - es / 4 - 1;
        else ech = es;
        chk(int'(bit_cnt) == m_pos, "R1 R4 R8 bit_cnt", bit_cnt, m_pos);
        chk(sync_out == m_sync, "R2 R3 sync_out", sync_out, m_sync);
        chk(sync_err == m_err, "R5 sync_err", sync_err, m_err);
        chk(int'(slot_cnt) == es, "R6 slot_cnt", slot_cnt, es);
        chk(int'(dont_care) == edc, "R7 dont_care", dont_care, edc);
        chk(int'(ds0_chan) == ech, "R7 ds0_chan", ds0_chan, ech);
      end
    end
  end

  function automatic void bool_t_dummy();
  endfunction

  // drive ext_sync as a periodic pulse train; period 0 = idle
  task automatic run(int cycles, int period, int phase, int width);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      ext_sync = (period > 0) && (((i + phase) % period) < width);
    end
  endtask

  int n_err_seen = 0;
  always @(negedge clk) if (!rst && sync_err) n_err_seen++;

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R2: base T1 generating its own pulse
    run(600, 0, 0, 0);
    // R3: external pulses ignored while driving
    run(400, 193, 50, 1);
    // R8: switch to base E1 mid-frame
    cfg_mode = 3'd1; run(800, 0, 0, 0);
    // R4 R5: base E1 as input, misplaced then aligned pulses
    cfg_sync_in = 1'b1; run(1100, 256, 100, 1);
    // R7: 2.048 high-speed carrying T1
    cfg_mode = 3'd2; cfg_t1 = 1'b1; run(1100, 256, 30, 1);
    // R6: 4.096 high-speed, E1 content
    cfg_mode = 3'd3; cfg_t1 = 1'b0; run(2200, 512, 7, 1);
    // R6 R7: 8.192 high-speed carrying T1
    cfg_mode = 3'd4; cfg_t1 = 1'b1; run(4200, 1024, 300, 1);
    // R4: four-bit pulse straddling the seam
    cfg_mode = 3'd5; run(4200, 1024, 500, 4);
    // R4: two-bit pulse straddling the seam
    cfg_mode = 3'd6; cfg_t1 = 1'b0; run(4200, 1024, 900, 2);
    // R1: code 7 behaves as code 4
    cfg_mode = 3'd7; run(2200, 1024, 0, 1);
    // R2 R8: back to driving base T1
    cfg_mode = 3'd0; cfg_sync_in = 1'b0; run(1000, 0, 0, 0);
    // R9: reset in mid-run with a new configuration
    cfg_mode = 3'd3; rst = 1'b1; run(4, 0, 0, 0);
    rst = 1'b0; run(1200, 512, 0, 1);
    // R5: misplaced pulses must have been reported at least once
    chk(n_err_seen > 0, "R5 sync_err ever raised", n_err_seen, 1);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule